// File: doc/BRIEF.md
# Nested priority interrupt controller

This block decides which interrupt a small CPU takes next. Up to thirty maskable request lines each have a two-bit software priority, and a non-maskable software trap sits above them. The priorities live in eight byte-wide registers written over a simple register bus. Each cycle the block compares the pending requests against the CPU's current priority level. It offers a winner, chosen by software priority first and by vector index second, and gives its vector address and the level the CPU must adopt.

The CPU signals that it is taking the offered interrupt with an entry strobe and that it is leaving a routine with a return strobe. On entry the block saves the running level on a small internal stack and loads the winner's level. On return it restores the saved level. A direct level load models instructions that rewrite the level. Because a routine runs at its own level, any request with a strictly higher level preempts it, so routines nest. Any level below 3 therefore lets nesting happen.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every priority register reads 0xFF, the current level is code 11 and the save stack is empty, so no maskable request is offered.
- R2: A register write updates each two-bit field separately. A field whose written code is 10 keeps its old value. For example, a register holding 0xCF that is written with 0x64 reads back 0x44. Vector x uses bits 2*(x mod 4)+1 : 2*(x mod 4) of register x/4.
- R3: Level codes are 10 = level 0, 01 = level 1, 00 = level 2 and 11 = level 3. A maskable request is offered only when its level is strictly greater than the current level, and `irq_lvl` carries the winner's code.
- R4: Among eligible maskable requests the highest level wins, and on equal level the lowest vector index wins.
- R5: The offered address is 0x008008 + 4*x for maskable vector x, and 0x008004 for the trap.
- R6: A trap request is offered at any current level, takes precedence over every maskable request, and sets the current level to code 11 when it is entered.
- R7: Vector 0's priority field can be written and read back, but vector 0 always arbitrates as level 3.
- R8: An entry strobe while a request is offered pushes the current level and loads the offered level. An entry strobe with nothing offered changes neither the level nor the stack.
- R9: A return strobe pops the most recently saved level into the current level. A return with an empty stack leaves the level unchanged.
- R10: A level-load strobe copies `lvl_in` into the current level. When strobes coincide, an effective entry wins over a return, and a return wins over a level load.
- R11: If the priority of a vector being serviced is raised while that vector is still pending, it is offered again. Lowering it leaves the current level unchanged.
- R12: The stack holds four levels. An entry with the stack full overwrites the newest saved level, so the later returns restore that value, then the older ones, and then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Priority register write strobe |
| reg_addr | input | 3 | Priority register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the addressed register |
| irq_req | input | 30 | Pending maskable requests, bit x for vector x |
| trap_req | input | 1 | Pending software trap |
| enter | input | 1 | CPU takes the offered interrupt |
| iret | input | 1 | CPU returns from a routine |
| lvl_load | input | 1 | CPU writes the level directly |
| lvl_in | input | 2 | Level code for a direct load |
| cur_lvl | output | 2 | Current level code |
| irq_take | output | 1 | An interrupt is offered |
| irq_trap | output | 1 | The offered interrupt is the trap |
| irq_idx | output | 5 | Offered maskable vector index (meaningless for the trap) |
| irq_addr | output | 24 | Offered vector address |
| irq_lvl | output | 2 | Level code that entry will load |

## Verification
The assertions assume the CPU raises the entry strobe only in a cycle where it has seen an offered interrupt, and that the strobes and register writes are synchronous single-cycle pulses. The bench changes every input shortly after a rising edge and samples at least a nanosecond later, so each strobe is seen at exactly one edge. The stack overflow case is reached only through repeated trap entries with direct level loads between them, because maskable entries alone cannot climb past level 3.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_VEC   = 30,
  parameter int NUM_REG   = 8,
  parameter int STK_DEPTH = 4,
  parameter int ADDR_W    = 24,
  parameter int TLI_VEC   = 0,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 24'h008008,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 24'h008004
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [$clog2(NUM_REG)-1:0] reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic [NUM_VEC-1:0]         irq_req,
  input  logic                       trap_req,
  input  logic                       enter,
  input  logic                       iret,
  input  logic                       lvl_load,
  input  logic [1:0]                 lvl_in,
  output logic [1:0]                 cur_lvl,
  output logic                       irq_take,
  output logic                       irq_trap,
  output logic [$clog2(NUM_REG*4)-1:0] irq_idx,
  output logic [ADDR_W-1:0]          irq_addr,
  output logic [1:0]                 irq_lvl
);
  localparam int IDX_W = $clog2(NUM_REG * 4);
  localparam int SP_W  = $clog2(STK_DEPTH + 1);
  localparam int PI_W  = $clog2(STK_DEPTH);
  localparam logic [1:0] LVL3 = 2'b11;

  function automatic logic [1:0] code2num(input logic [1:0] c);
    return {~(c[1] ^ c[0]), c[0]};
  endfunction

  function automatic logic [1:0] num2code(input logic [1:0] n);
    return {~(n[1] ^ n[0]), n[0]};
  endfunction

  logic [NUM_REG*8-1:0] prio;
  logic [1:0]           cur_q;
  logic [SP_W-1:0]      sp;
  logic [1:0]           stk [STK_DEPTH];
  logic [1:0]           vnum [NUM_VEC];
  logic [NUM_VEC-1:0]   elig;
  logic                 best_found;
  logic [1:0]           best_lvl;
  logic [IDX_W-1:0]     best_idx;
  logic                 take_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prio <= '1;
    else if (reg_wr)
      for (int f = 0; f < 4; f++)
        if (reg_wdata[2*f +: 2] != 2'b10)
          prio[8*reg_addr + 2*f +: 2] <= reg_wdata[2*f +: 2];

  assign reg_rdata = prio[8*reg_addr +: 8];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v == TLI_VEC) begin : g_tli
      assign vnum[v] = 2'd3;
    end else begin : g_sw
      assign vnum[v] = code2num(prio[2*v +: 2]);
    end
    assign elig[v] = irq_req[v] && (vnum[v] > code2num(cur_q));
  end

  always_comb begin
    best_found = 1'b0;
    best_lvl   = 2'd0;
    best_idx   = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (elig[v] && (!best_found || vnum[v] >= best_lvl)) begin
        best_found = 1'b1;
        best_lvl   = vnum[v];
        best_idx   = IDX_W'(v);
      end
  end

  assign irq_trap = trap_req;
  assign irq_take = trap_req | best_found;
  assign irq_idx  = best_idx;
  assign irq_lvl  = trap_req ? LVL3 : num2code(best_lvl);
  assign irq_addr = trap_req ? TRAP_ADDR : VEC_BASE + (ADDR_W'(best_idx) << 2);
  assign cur_lvl  = cur_q;
  assign take_in  = enter && irq_take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur_q <= LVL3;
      sp    <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= LVL3;
    end else if (take_in) begin
      cur_q <= irq_lvl;
      if (sp < SP_W'(STK_DEPTH)) begin
        stk[PI_W'(sp)] <= cur_q;
        sp             <= sp + SP_W'(1);
      end else
        stk[PI_W'(STK_DEPTH - 1)] <= cur_q;
    end else if (iret) begin
      if (sp != '0) begin
        cur_q <= stk[PI_W'(sp - SP_W'(1))];
        sp    <= sp - SP_W'(1);
      end
    end else if (lvl_load)
      cur_q <= lvl_in;

  // R12
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(STK_DEPTH));

  // R6
  trap_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter && trap_req |=> cur_q == LVL3);

  // R2
  lvl0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata == 8'hAA |=> $stable(prio));

  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && !irq_trap |-> code2num(irq_lvl) > code2num(cur_q));

  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iret && !take_in && sp == '0 |=> $stable(cur_q));
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [29:0] irq_req = '0;
  logic        trap_req = 1'b0, enter = 1'b0, iret = 1'b0, lvl_load = 1'b0;
  logic [1:0]  lvl_in = '0;
  logic [1:0]  cur_lvl, irq_lvl;
  logic        irq_take, irq_trap;
  logic [4:0]  irq_idx;
  logic [23:0] irq_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .trap_req(trap_req), .enter(enter), .iret(iret), .lvl_load(lvl_load),
    .lvl_in(lvl_in), .cur_lvl(cur_lvl), .irq_take(irq_take),
    .irq_trap(irq_trap), .irq_idx(irq_idx), .irq_addr(irq_addr),
    .irq_lvl(irq_lvl));

  // {current level code, requests, expected take, expected index, expected level code}
  localparam int NT = 12;
  localparam logic [39:0] TBL [NT] = '{
    {2'b10, 30'h0000_0010, 1'b1, 5'd4,  2'b01},
    {2'b01, 30'h0000_0010, 1'b0, 5'd0,  2'b00},
    {2'b01, 30'h0000_0030, 1'b1, 5'd5,  2'b00},
    {2'b10, 30'h0000_0060, 1'b1, 5'd5,  2'b00},
    {2'b10, 30'h0000_0240, 1'b1, 5'd6,  2'b00},
    {2'b10, 30'h2000_0010, 1'b1, 5'd29, 2'b11},
    {2'b00, 30'h0000_0160, 1'b0, 5'd0,  2'b00},
    {2'b00, 30'h0010_0020, 1'b1, 5'd20, 2'b11},
    {2'b11, 30'h0010_0000, 1'b0, 5'd0,  2'b00},
    {2'b11, 30'h0000_0001, 1'b0, 5'd0,  2'b00},
    {2'b00, 30'h0000_0003, 1'b1, 5'd0,  2'b11},
    {2'b10, 30'h0000_0000, 1'b0, 5'd0,  2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; irq_req = '0; trap_req = 0; enter = 0; iret = 0; lvl_load = 0; reg_wr = 0;
    tick; tick; rst_n = 1'b1; tick;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick; reg_wr = 1'b0; #1;
  endtask

  task automatic setlvl(input logic [1:0] c);
    lvl_in = c; lvl_load = 1'b1; tick; lvl_load = 1'b0; #1;
  endtask

  task automatic pulse_enter;
    enter = 1'b1; tick; enter = 1'b0; #1;
  endtask

  task automatic pulse_iret;
    iret = 1'b1; tick; iret = 1'b0; #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] allreg;
    do_reset;
    // R1 reset state
    allreg = 8'hFF;
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      allreg = allreg & reg_rdata;
    end
    chk("R1 regs", {24'h0, allreg}, 32'hFF);
    chk("R1 level", {30'h0, cur_lvl}, 32'h3);
    irq_req = 30'h3FFF_FFFE; #1;
    chk("R1 no offer", {31'h0, irq_take}, 32'h0);
    irq_req = '0;

    // configure: v0 field 01, v4 L1, v5 L2, v6 L2, v7 L1, v8-v11 L2, rest L3
    wr(3'd0, 8'hFD);
    wr(3'd1, 8'h41);
    wr(3'd2, 8'h00);
    reg_addr = 3'd0; #1;
    chk("R7 readback", {24'h0, reg_rdata}, 32'hFD);

    for (int t = 0; t < NT; t++) begin
      setlvl(TBL[t][39:38]);
      irq_req = TBL[t][37:8]; #1;
      chk("R3 take", {31'h0, irq_take}, {31'h0, TBL[t][7]});
      if (TBL[t][7]) begin
        chk("R4 index", {27'h0, irq_idx}, {27'h0, TBL[t][6:2]});
        chk("R3 level", {30'h0, irq_lvl}, {30'h0, TBL[t][1:0]});
        chk("R5 address", {8'h0, irq_addr}, 32'h008008 + 4 * TBL[t][6:2]);
      end
      irq_req = '0;
    end

    // R7 vector 0 arbitrates at level 3 despite field 01
    setlvl(2'b00);
    irq_req = 30'h1; #1;
    chk("R7 tli offered", {31'h0, irq_take}, 32'h1);
    chk("R7 tli level", {30'h0, irq_lvl}, 32'h3);
    irq_req = '0;

    // R2 field-wise level-0 filter
    do_reset;
    wr(3'd3, 8'hCF);
    wr(3'd3, 8'h64);
    reg_addr = 3'd3; #1;
    chk("R2 filter", {24'h0, reg_rdata}, 32'h44);
    wr(3'd4, 8'hAA);
    reg_addr = 3'd4; #1;
    chk("R2 all level0", {24'h0, reg_rdata}, 32'hFF);

    // R6 trap at level 3
    do_reset;
    trap_req = 1'b1; irq_req = 30'h2000_0000; #1;
    chk("R6 trap offered", {30'h0, irq_take, irq_trap}, 32'h3);
    chk("R5 trap address", {8'h0, irq_addr}, 32'h008004);
    setlvl(2'b10);
    pulse_enter;
    chk("R6 trap level", {30'h0, cur_lvl}, 32'h3);
    trap_req = 1'b0; irq_req = '0;

    // R8 R9 push and pop
    do_reset;
    wr(3'd1, 8'h41);
    setlvl(2'b10);
    irq_req = 30'h10; pulse_enter;
    chk("R8 enter L1", {30'h0, cur_lvl}, 32'h1);
    irq_req = 30'h20; pulse_enter;
    chk("R8 enter L2", {30'h0, cur_lvl}, 32'h0);
    irq_req = '0;
    pulse_iret;
    chk("R9 pop1", {30'h0, cur_lvl}, 32'h1);
    pulse_iret;
    chk("R9 pop2", {30'h0, cur_lvl}, 32'h2);
    pulse_iret;
    chk("R9 empty pop", {30'h0, cur_lvl}, 32'h2);

    // R8 enter with nothing offered
    setlvl(2'b11);
    pulse_enter;
    chk("R8 idle enter", {30'h0, cur_lvl}, 32'h3);
    pulse_iret;
    chk("R8 no push", {30'h0, cur_lvl}, 32'h3);

    // R10 precedence
    setlvl(2'b10);
    irq_req = 30'h10;
    enter = 1'b1; iret = 1'b1; lvl_load = 1'b1; lvl_in = 2'b11;
    tick; enter = 1'b0; iret = 1'b0; lvl_load = 1'b0; irq_req = '0; #1;
    chk("R10 enter wins", {30'h0, cur_lvl}, 32'h1);
    iret = 1'b1; lvl_load = 1'b1; lvl_in = 2'b00;
    tick; iret = 1'b0; lvl_load = 1'b0; #1;
    chk("R10 return wins", {30'h0, cur_lvl}, 32'h2);
    setlvl(2'b01);
    chk("R10 direct load", {30'h0, cur_lvl}, 32'h1);

    // R11 re-entry
    do_reset;
    wr(3'd3, 8'h00);
    setlvl(2'b10);
    irq_req = 30'h1000; pulse_enter;
    chk("R11 in service", {30'h0, cur_lvl}, 32'h0);
    chk("R11 not offered", {31'h0, irq_take}, 32'h0);
    wr(3'd3, 8'h03);
    chk("R11 re-entry offer", {31'h0, irq_take}, 32'h1);
    chk("R11 re-entry index", {27'h0, irq_idx}, 32'd12);
    chk("R11 re-entry level", {30'h0, irq_lvl}, 32'h3);
    wr(3'd3, 8'h01);
    chk("R11 lowered no offer", {31'h0, irq_take}, 32'h0);
    chk("R11 level kept", {30'h0, cur_lvl}, 32'h0);
    irq_req = '0;

    // R12 overflow through trap entries
    do_reset;
    trap_req = 1'b1;
    setlvl(2'b10); pulse_enter;
    setlvl(2'b01); pulse_enter;
    setlvl(2'b00); pulse_enter;
    setlvl(2'b10); pulse_enter;
    setlvl(2'b01); pulse_enter;
    trap_req = 1'b0;
    pulse_iret; chk("R12 pop overwritten", {30'h0, cur_lvl}, 32'h1);
    pulse_iret; chk("R12 pop 3", {30'h0, cur_lvl}, 32'h0);
    pulse_iret; chk("R12 pop 2", {30'h0, cur_lvl}, 32'h1);
    pulse_iret; chk("R12 pop 1", {30'h0, cur_lvl}, 32'h2);
    pulse_iret; chk("R12 empty", {30'h0, cur_lvl}, 32'h2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule